// File: doc/BRIEF.md
# Byte-Serial CRC-16 Engine With Selectable Start Value

This block computes a 16-bit cyclic redundancy check over a stream of bytes. The bytes arrive one per clock from a buffer. A start strobe loads one of four fixed start values, chosen by a 2-bit selector. Every valid byte after that folds into the running remainder in a single cycle. The byte flagged as the last one ends the calculation.

When the calculation ends, the engine raises a ready flag and a one-cycle interrupt pulse. It also reports whether the final remainder is zero. A zero remainder is the expected outcome when the stream already ends with its own check bytes, low byte first. The running remainder is always visible as a high byte and a low byte on separate outputs.

The generator polynomial is fixed at x^16 + x^12 + x^5 + 1. Data bits are taken least significant first, and the register shifts toward bit 0. In that reflected form the polynomial constant is 8408h. No final inversion is applied.

Top module: `crc16_engine`

## Requirements
- R1: After reset the result reads 0000h, and ready, ok and the interrupt are all 0.
- R2: A start strobe loads the start value named by the selector: 00 gives 0000h, 01 gives 6363h, 10 gives A671h, 11 gives FFFFh. The value shows on the result outputs in the cycle after the strobe, and the same edge clears ready and ok.
- R3: Between a start and the last byte, each cycle with byte valid high folds one byte into the remainder. The fold uses the reflected constant 8408h with data bit 0 first, and the new value appears one cycle later. Over the ASCII bytes "123456789" the finished remainders are 2189h for start 0000h, BF05h for 6363h and 6F91h for FFFFh.
- R4: A valid byte taken together with the end-of-data indication finishes the calculation, and ready reads 1 from the next cycle on.
- R5: ok goes to 1 at completion only when the final remainder is 0000h, and a start strobe returns it to 0.
- R6: The interrupt output is high for exactly one cycle: the first cycle in which ready reads 1.
- R7: Byte strobes that arrive while no calculation is running are ignored. This covers strobes before the first start and after completion, and the result and status stay as they were.
- R8: When the start strobe and byte valid are high in the same cycle, the start wins and the byte is dropped.
- R9: The high result output carries remainder bits 15:8 and the low result output carries bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load the start value and begin a calculation |
| preset_sel_i | input | 2 | Start value selector |
| byte_valid_i | input | 1 | A data byte is offered this cycle |
| byte_i | input | 8 | Data byte |
| last_i | input | 1 | The offered byte is the final one |
| crc_msb_o | output | 8 | Remainder bits 15:8 |
| crc_lsb_o | output | 8 | Remainder bits 7:0 |
| ready_o | output | 1 | Calculation finished |
| ok_o | output | 1 | Finished with a zero remainder |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
Some rules are checked by the assertions on every cycle:
- the interrupt is a single-cycle pulse that coincides with the rise of ready;
- ok never appears without ready or with a non-zero result;
- a start always clears the status;
- the result holds steady whenever no calculation is running.

The arithmetic needs the bench's scenarios. These are the remainder values for the known message under each start value, and the zero residue when check bytes are appended. The scenarios also cover the dropping of a byte that collides with a start, and the exact start values the selector loads.

// File: rtl/crc16_engine.sv
module crc16_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] preset_sel_i,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       last_i,
  output logic [7:0] crc_msb_o,
  output logic [7:0] crc_lsb_o,
  output logic       ready_o,
  output logic       ok_o,
  output logic       irq_o
);

  localparam logic [15:0] POLY_REV = 16'h8408;

  logic [15:0] crc_q;
  logic [15:0] crc_nxt;
  logic [15:0] preset;
  logic        busy_q;
  logic        take;

  function automatic logic [15:0] fold_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r >> 1) ^ (((r[0] ^ d[i]) == 1'b1) ? POLY_REV : 16'h0000);
    return r;
  endfunction

  always_comb begin
    unique case (preset_sel_i)
      2'b00:   preset = 16'h0000;
      2'b01:   preset = 16'h6363;
      2'b10:   preset = 16'hA671;
      default: preset = 16'hFFFF;
    endcase
  end

  assign crc_nxt = fold_byte(crc_q, byte_i);
  assign take    = busy_q && byte_valid_i && !start_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= 16'h0000;
      busy_q  <= 1'b0;
      ready_o <= 1'b0;
      ok_o    <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (start_i) begin
        crc_q   <= preset;
        busy_q  <= 1'b1;
        ready_o <= 1'b0;
        ok_o    <= 1'b0;
      end else if (take) begin
        crc_q <= crc_nxt;
        if (last_i) begin
          busy_q  <= 1'b0;
          ready_o <= 1'b1;
          ok_o    <= (crc_nxt == 16'h0000);
          irq_o   <= 1'b1;
        end
      end
    end
  end

  assign crc_msb_o = crc_q[15:8];
  assign crc_lsb_o = crc_q[7:0];

endmodule

module crc16_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy,
  input logic [7:0] crc_msb_o,
  input logic [7:0] crc_lsb_o,
  input logic       ready_o,
  input logic       ok_o,
  input logic       irq_o
);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ready_o && !$past(ready_o)));

  p_rise_gives_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> irq_o);

  p_ok_needs_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ok_o |-> (ready_o && {crc_msb_o, crc_lsb_o} == 16'h0000));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!ready_o && !ok_o));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> ($stable(crc_msb_o) && $stable(crc_lsb_o) && $stable(ready_o)));

endmodule

bind crc16_engine crc16_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy_q),
  .crc_msb_o(crc_msb_o), .crc_lsb_o(crc_lsb_o),
  .ready_o(ready_o), .ok_o(ok_o), .irq_o(irq_o)
);

// File: tb/crc16_engine_tb.sv
module crc16_engine_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [1:0] preset_sel_i;
  logic       byte_valid_i;
  logic [7:0] byte_i;
  logic       last_i;
  logic [7:0] crc_msb_o, crc_lsb_o;
  logic       ready_o, ok_o, irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [17:0] VEC [3] = '{
    {2'b00, 16'h2189}, {2'b01, 16'hBF05}, {2'b11, 16'h6F91}
  };
  localparam logic [7:0] MSG [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35,
                                    8'h36, 8'h37, 8'h38, 8'h39};

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .preset_sel_i(preset_sel_i),
    .byte_valid_i(byte_valid_i), .byte_i(byte_i), .last_i(last_i),
    .crc_msb_o(crc_msb_o), .crc_lsb_o(crc_lsb_o),
    .ready_o(ready_o), .ok_o(ok_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] bitrev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  // Non-reflected model on a bit-reversed register
  function automatic logic [15:0] model_msg(input logic [15:0] init);
    logic [15:0] r;
    logic fb;
    r = bitrev16(init);
    for (int b = 0; b < 9; b++)
      for (int i = 0; i < 8; i++) begin
        fb = r[15] ^ MSG[b][i];
        r = {r[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    return bitrev16(r);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] sel, input logic with_byte);
    start_i = 1'b1; preset_sel_i = sel;
    byte_valid_i = with_byte; byte_i = 8'hA5; last_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0; byte_valid_i = 1'b0;
  endtask

  task automatic feed(input logic [7:0] d, input logic lst);
    byte_valid_i = 1'b1; byte_i = d; last_i = lst;
    @(negedge clk);
    byte_valid_i = 1'b0; last_i = 1'b0;
  endtask

  task automatic feed_msg(input logic lst_on_end);
    for (int i = 0; i < 9; i++) feed(MSG[i], lst_on_end && (i == 8));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] res;
    rst_n = 1'b0; start_i = 1'b0; preset_sel_i = 2'b00;
    byte_valid_i = 1'b0; byte_i = 8'h00; last_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 result", {crc_msb_o, crc_lsb_o}, 16'h0000);
    chk("R1 flags", {13'b0, ready_o, ok_o, irq_o}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: bytes before any start are ignored
    feed(8'h5A, 1'b1);
    chk("R7 before start", {crc_msb_o, crc_lsb_o, 5'b0, ready_o, ok_o, irq_o}, 16'h0000);

    // R2 / R9: preset loading
    for (int s = 0; s < 4; s++) begin
      logic [15:0] exp;
      exp = (s == 0) ? 16'h0000 : (s == 1) ? 16'h6363 : (s == 2) ? 16'hA671 : 16'hFFFF;
      do_start(2'(s), 1'b0);
      chk("R2 preset", {crc_msb_o, crc_lsb_o}, exp);
      chk("R9 msb byte", {8'h00, crc_msb_o}, {8'h00, exp[15:8]});
      chk("R2 ready cleared", {15'b0, ready_o}, 16'h0000);
    end

    // R3 / R4 / R6: vector table
    for (int v = 0; v < 3; v++) begin
      do_start(VEC[v][17:16], 1'b0);
      feed_msg(1'b1);
      chk("R3 remainder", {crc_msb_o, crc_lsb_o}, VEC[v][15:0]);
      chk("R4 ready", {15'b0, ready_o}, 16'h0001);
      chk("R6 irq high", {15'b0, irq_o}, 16'h0001);
      @(negedge clk);
      chk("R6 irq low", {15'b0, irq_o}, 16'h0000);
    end

    // R3: start A671h against the independent model
    do_start(2'b10, 1'b0);
    feed_msg(1'b1);
    chk("R3 A671 remainder", {crc_msb_o, crc_lsb_o}, model_msg(16'hA671));

    // R7: bytes after completion are ignored
    res = {crc_msb_o, crc_lsb_o};
    feed(8'hC3, 1'b0);
    feed(8'h3C, 1'b1);
    chk("R7 after done", {crc_msb_o, crc_lsb_o}, res);
    chk("R7 ready kept", {14'b0, ready_o, irq_o}, 16'h0002);

    // R5: residue zero when check bytes appended
    do_start(2'b01, 1'b0);
    feed_msg(1'b0);
    chk("R4 not ready mid-stream", {15'b0, ready_o}, 16'h0000);
    feed(8'h05, 1'b0);
    feed(8'hBF, 1'b1);
    chk("R5 residue", {crc_msb_o, crc_lsb_o}, 16'h0000);
    chk("R5 ok set", {14'b0, ready_o, ok_o}, 16'h0003);
    do_start(2'b01, 1'b0);
    chk("R5 ok cleared by start", {14'b0, ready_o, ok_o}, 16'h0000);
    feed_msg(1'b0);
    feed(8'h05, 1'b0);
    feed(8'hBE, 1'b1);
    chk("R5 bad residue", {14'b0, ready_o, ok_o}, 16'h0002);

    // R8: start wins over a same-cycle byte
    do_start(2'b11, 1'b1);
    chk("R8 byte dropped", {crc_msb_o, crc_lsb_o}, 16'hFFFF);
    feed_msg(1'b1);
    chk("R8 stream intact", {crc_msb_o, crc_lsb_o}, 16'h6F91);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule